// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table that lives in ordinary memory. A requester presents a virtual address together with a write flag and a user-mode flag. The block then reads the directory entry that the root address and the top ten address bits select. It reads a leaf entry only when the directory entry is valid. From the leaf entry it returns either a physical address or a fault code.

Pages are 8 KB, so the low 13 address bits pass straight through as the page offset. The upper 19 bits index the two levels: ten bits for the directory and nine bits for the leaf table. After a permitted access, the walker sets the leaf entry's referenced flag, and also its modified flag when the access is a write. It writes the entry back through the same memory port, but only when one of those flags actually changes.

Top module: `pt_walker`

## Requirements
- R1: On a successful translation, the returned physical address is the leaf entry's bits 31:13 joined with virtual address bits 12:0, and the fault code is 0.
- R2: The first memory read of every walk targets `pt_root_i + 4 * vaddr[31:22]`.
- R3: When the directory entry is valid, the second read targets `{dir[31:13], 13'b0} + 4 * vaddr[21:13]`.
- R4: A directory entry with bit 0 (valid) clear gives fault code 1 (not present) after exactly one memory read and no write.
- R5: A leaf entry with bit 0 clear gives fault code 1 after two reads and no write.
- R6: Protection is checked on the leaf entry only. Fault code 2 is returned when a write targets an entry with bit 4 (read-only) set, or when a user-mode access targets an entry with bit 3 (user-allowed) clear. No write-back follows a fault, and protection bits in the directory entry have no effect.
- R7: After a permitted access, the leaf entry is written back to its own address with bit 1 (referenced) set, and with bit 2 (modified) also set on a write. All other bits are unchanged.
- R8: When the referenced flag, and for writes the modified flag, are already set, no write-back is issued.
- R9: `xl_done_o` is high for exactly one cycle per walk, the physical address is zero whenever the fault code is nonzero, and `xl_ready_o` is high only while no walk is in progress.
- R10: A memory request holds its address, direction and write data unchanged until `mem_ack_i`. Read data is taken in the acknowledge cycle.
- R11: While reset is asserted and right after it, `xl_ready_o` is high and `mem_req_o` and `xl_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_root_i | input | 32 | Physical address of the directory table, sampled when a request is accepted |
| xl_valid_i | input | 1 | Translation request |
| xl_ready_o | output | 1 | Walker idle, request accepted on this cycle |
| xl_vaddr_i | input | 32 | Virtual address to translate |
| xl_write_i | input | 1 | Access is a write |
| xl_user_i | input | 1 | Access comes from user mode |
| xl_done_o | output | 1 | One-cycle result strobe |
| xl_paddr_o | output | 32 | Physical address (zero on fault) |
| xl_fault_o | output | 2 | 0 ok, 1 not present, 2 protection |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data (updated leaf entry) |
| mem_ack_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |

## Verification
Directed walks cover each exit of the walk: a missing directory entry, a missing leaf, a read-only write, a supervisor-only page reached from user mode, a clean read, a first write, and a repeat write. These separate the single-read fault path from the two-read path, and show which flag change forces a write-back. Extreme offsets and all-ones indices test the address arithmetic at its edges. A directory entry that carries protection bits shows that the first level does not check them. Random walks over a randomly filled table, with random memory latency, mix valid and invalid entries and all flag combinations. Against a reference model in the bench, they confirm read addresses, access counts, written entry values and results together.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int PTE_W  = 32;
  localparam int OFF_W  = 13;
  localparam int IX1_W  = 10;
  localparam int IX2_W  = 9;
  localparam int PTE_SH = 2;                 // log2 of entry size in bytes
  localparam int PFN_W  = PA_W - OFF_W;
  localparam int IX2_LSB = OFF_W;
  localparam int IX1_LSB = OFF_W + IX2_W;

  // entry flag positions
  localparam int PTE_V   = 0;
  localparam int PTE_REF = 1;
  localparam int PTE_MOD = 2;
  localparam int PTE_USR = 3;
  localparam int PTE_RO  = 4;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_L1,
    ST_RD_L2,
    ST_UPD,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PA_W-1:0]  root_i,
  input  logic [PFN_W-1:0] dir_pfn_i,
  input  logic [PFN_W-1:0] leaf_pfn_i,
  output logic [PA_W-1:0]  l1_addr_o,
  output logic [PA_W-1:0]  l2_addr_o,
  output logic [PA_W-1:0]  leaf_paddr_o
);
  localparam int L1_OFS_W = IX1_W + PTE_SH;
  localparam int L2_OFS_W = IX2_W + PTE_SH;

  logic [IX1_W-1:0]    idx1;
  logic [IX2_W-1:0]    idx2;
  logic [OFF_W-1:0]    pg_off;
  logic [L1_OFS_W-1:0] l1_ofs;
  logic [L2_OFS_W-1:0] l2_ofs;
  logic [PA_W-1:0]     l2_tbl;

  always_comb begin
    idx1   = vaddr_i[IX1_LSB +: IX1_W];
    idx2   = vaddr_i[IX2_LSB +: IX2_W];
    pg_off = vaddr_i[OFF_W-1:0];
    l1_ofs = {idx1, {PTE_SH{1'b0}}};
    l2_ofs = {idx2, {PTE_SH{1'b0}}};
    l2_tbl = {dir_pfn_i, {OFF_W{1'b0}}};
    l1_addr_o    = root_i + PA_W'(l1_ofs);
    l2_addr_o    = l2_tbl + PA_W'(l2_ofs);
    leaf_paddr_o = {leaf_pfn_i, pg_off};
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_write_i,
  input  logic             is_user_i,
  output fault_e           fault_o,
  output logic [PTE_W-1:0] pte_upd_o,
  output logic             wb_need_o
);
  logic ro_hit;
  logic usr_hit;
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    ro_hit  = is_write_i && pte_i[PTE_RO];
    usr_hit = is_user_i && !pte_i[PTE_USR];
    if (!pte_i[PTE_V])          fault_o = FLT_ABSENT;
    else if (ro_hit || usr_hit) fault_o = FLT_PROT;
    else                        fault_o = FLT_NONE;

    set_mask          = '0;
    set_mask[PTE_REF] = 1'b1;
    set_mask[PTE_MOD] = is_write_i;
    pte_upd_o = pte_i | set_mask;
    wb_need_o = (fault_o == FLT_NONE) && (pte_upd_o != pte_i);
  end
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  input  logic [PA_W-1:0]  root_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_fault_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  // helper datapath
  input  logic [PA_W-1:0]  l1_addr_i,
  input  logic [PA_W-1:0]  l2_addr_i,
  input  logic [PA_W-1:0]  leaf_paddr_i,
  input  fault_e           ev_fault_i,
  input  logic [PTE_W-1:0] ev_pte_i,
  input  logic             ev_wb_i,
  output logic [VA_W-1:0]  vaddr_o,
  output logic [PA_W-1:0]  root_o,
  output logic [PFN_W-1:0] dir_pfn_o,
  output logic             write_o,
  output logic             user_o
);
  walk_st_e         st_q, st_d;
  logic [VA_W-1:0]  vaddr_q, vaddr_d;
  logic             write_q, write_d;
  logic             user_q, user_d;
  logic [PA_W-1:0]  root_q, root_d;
  logic [PFN_W-1:0] dir_q, dir_d;
  logic [PTE_W-1:0] wb_q, wb_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  fault_e           flt_q, flt_d;

  logic cap_en, dir_en, res_en;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    vaddr_d = vaddr_q;
    write_d = write_q;
    user_d  = user_q;
    root_d  = root_q;
    dir_d   = dir_q;
    wb_d    = wb_q;
    pa_d    = pa_q;
    flt_d   = flt_q;
    cap_en  = 1'b0;
    dir_en  = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          cap_en  = 1'b1;
          vaddr_d = req_vaddr_i;
          write_d = req_write_i;
          user_d  = req_user_i;
          root_d  = root_i;
          st_d    = ST_RD_L1;
        end
      end
      ST_RD_L1: begin
        if (mem_ack_i) begin
          if (mem_rdata_i[PTE_V]) begin
            dir_en = 1'b1;
            dir_d  = mem_rdata_i[PTE_W-1 -: PFN_W];
            st_d   = ST_RD_L2;
          end else begin
            res_en = 1'b1;
            flt_d  = FLT_ABSENT;
            pa_d   = '0;
            st_d   = ST_DONE;
          end
        end
      end
      ST_RD_L2: begin
        if (mem_ack_i) begin
          res_en = 1'b1;
          flt_d  = ev_fault_i;
          pa_d   = (ev_fault_i == FLT_NONE) ? leaf_paddr_i : '0;
          wb_d   = ev_pte_i;
          st_d   = ev_wb_i ? ST_UPD : ST_DONE;
        end
      end
      ST_UPD: begin
        if (mem_ack_i) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      write_q <= 1'b0;
      user_q  <= 1'b0;
      root_q  <= '0;
    end else if (cap_en) begin
      vaddr_q <= vaddr_d;
      write_q <= write_d;
      user_q  <= user_d;
      root_q  <= root_d;
    end
  end

  // directory pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  // result and write-back entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q  <= '0;
      pa_q  <= '0;
      flt_q <= FLT_NONE;
    end else if (res_en) begin
      wb_q  <= wb_d;
      pa_q  <= pa_d;
      flt_q <= flt_d;
    end
  end

  // outputs
  always_comb begin
    req_ready_o = (st_q == ST_IDLE);
    mem_req_o   = (st_q == ST_RD_L1) || (st_q == ST_RD_L2) || (st_q == ST_UPD);
    mem_we_o    = (st_q == ST_UPD);
    mem_addr_o  = (st_q == ST_RD_L1) ? l1_addr_i : l2_addr_i;
    mem_wdata_o = wb_q;
    rsp_valid_o = (st_q == ST_DONE);
    rsp_paddr_o = pa_q;
    rsp_fault_o = flt_q;
    vaddr_o     = vaddr_q;
    root_o      = root_q;
    dir_pfn_o   = dir_q;
    write_o     = write_q;
    user_o      = user_q;
  end

  // R10: request held until acknowledged
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R9: single-cycle result strobe
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  // R9: idle means no memory traffic and no result
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o));

  // R4: invalid directory entry ends the walk without a second read
  assert_skip_leaf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD_L1 && mem_ack_i && !mem_rdata_i[PTE_V]) |=>
      (rsp_valid_o && rsp_fault_o == FLT_ABSENT && !mem_req_o));

  // R6: protection fault never followed by a write-back
  assert_prot_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD_L2 && mem_ack_i && ev_fault_i == FLT_PROT) |=> !mem_we_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pt_root_i,
  input  logic             xl_valid_i,
  output logic             xl_ready_o,
  input  logic [VA_W-1:0]  xl_vaddr_i,
  input  logic             xl_write_i,
  input  logic             xl_user_i,
  output logic             xl_done_o,
  output logic [PA_W-1:0]  xl_paddr_o,
  output logic [1:0]       xl_fault_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  logic [PA_W-1:0]  l1_addr, l2_addr, leaf_paddr;
  fault_e           ev_fault;
  logic [PTE_W-1:0] ev_pte;
  logic             ev_wb;
  logic [VA_W-1:0]  vaddr_q;
  logic [PA_W-1:0]  root_q;
  logic [PFN_W-1:0] dir_pfn;
  logic             write_q, user_q;

  ptw_addr_gen u_addr (
    .vaddr_i      (vaddr_q),
    .root_i       (root_q),
    .dir_pfn_i    (dir_pfn),
    .leaf_pfn_i   (mem_rdata_i[PTE_W-1 -: PFN_W]),
    .l1_addr_o    (l1_addr),
    .l2_addr_o    (l2_addr),
    .leaf_paddr_o (leaf_paddr)
  );

  ptw_pte_eval u_eval (
    .pte_i      (mem_rdata_i),
    .is_write_i (write_q),
    .is_user_i  (user_q),
    .fault_o    (ev_fault),
    .pte_upd_o  (ev_pte),
    .wb_need_o  (ev_wb)
  );

  ptw_walk_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (xl_valid_i),
    .req_ready_o  (xl_ready_o),
    .req_vaddr_i  (xl_vaddr_i),
    .req_write_i  (xl_write_i),
    .req_user_i   (xl_user_i),
    .root_i       (pt_root_i),
    .rsp_valid_o  (xl_done_o),
    .rsp_paddr_o  (xl_paddr_o),
    .rsp_fault_o  (xl_fault_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .l1_addr_i    (l1_addr),
    .l2_addr_i    (l2_addr),
    .leaf_paddr_i (leaf_paddr),
    .ev_fault_i   (ev_fault),
    .ev_pte_i     (ev_pte),
    .ev_wb_i      (ev_wb),
    .vaddr_o      (vaddr_q),
    .root_o       (root_q),
    .dir_pfn_o    (dir_pfn),
    .write_o      (write_q),
    .user_o       (user_q)
  );

  // R1: offset bits pass through on success
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done_o && xl_fault_o == FLT_NONE) |->
      (xl_paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  // R9: physical address cleared on any fault
  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done_o && xl_fault_o != FLT_NONE) |-> (xl_paddr_o == '0));

  // R7: any written entry is valid and referenced
  assert_wb_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[PTE_REF] && mem_wdata_o[PTE_V]));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk;
  logic        rst_n;
  logic [31:0] pt_root;
  logic        xl_valid, xl_write, xl_user;
  logic [31:0] xl_vaddr;
  logic        xl_ready, xl_done;
  logic [31:0] xl_paddr;
  logic [1:0]  xl_fault;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [31:0] mem [logic [31:0]];
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_a0, rd_a1, wr_a, wr_d;

  localparam logic [31:0] ROOT = 32'h0010_0000;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .pt_root_i(pt_root),
    .xl_valid_i(xl_valid), .xl_ready_o(xl_ready), .xl_vaddr_i(xl_vaddr),
    .xl_write_i(xl_write), .xl_user_i(xl_user), .xl_done_o(xl_done),
    .xl_paddr_o(xl_paddr), .xl_fault_o(xl_fault),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory responder with random latency
  initial begin
    int lat_cnt = 0;
    int lat_tgt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        if (lat_cnt < lat_tgt) lat_cnt++;
        else begin
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_a = mem_addr;
            wr_d = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = rd(mem_addr);
            if (rd_cnt == 0) rd_a0 = mem_addr;
            if (rd_cnt == 1) rd_a1 = mem_addr;
            rd_cnt++;
          end
          mem_ack = 1'b1;
          lat_cnt = 0;
          lat_tgt = $urandom % 3;
        end
      end
    end
  end

  // one translation, compared with a model of the requirements
  task automatic run_case(input string tag, input logic [31:0] va, input bit wr, input bit usr);
    logic [31:0] a1, a2, e1, e2, exp_pa, exp_wd;
    logic [1:0]  exp_f;
    int          exp_rd, exp_wr, cyc;
    a1 = ROOT + {20'h0, va[31:22], 2'b00};
    e1 = rd(a1);
    a2 = 32'h0; exp_pa = 32'h0; exp_wd = 32'h0; exp_wr = 0; exp_rd = 1;
    if (!e1[0]) exp_f = 2'd1;
    else begin
      a2 = {e1[31:13], 13'h0} + {21'h0, va[21:13], 2'b00};
      e2 = rd(a2);
      exp_rd = 2;
      if (!e2[0]) exp_f = 2'd1;
      else if ((wr && e2[4]) || (usr && !e2[3])) exp_f = 2'd2;
      else begin
        exp_f  = 2'd0;
        exp_pa = {e2[31:13], va[12:0]};
        exp_wd = e2 | 32'h2 | (wr ? 32'h4 : 32'h0);
        if (exp_wd != e2) exp_wr = 1;
      end
    end
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    xl_valid = 1'b1; xl_vaddr = va; xl_write = wr; xl_user = usr;
    @(negedge clk);
    xl_valid = 1'b0; xl_vaddr = $urandom; xl_write = $urandom; xl_user = $urandom;
    cyc = 0;
    while (!xl_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check(tag, xl_done, 32'(xl_done), 32'h1, "result strobe");
    check(tag, xl_fault == exp_f, 32'(xl_fault), 32'(exp_f), "fault code");
    check(tag, xl_paddr == exp_pa, xl_paddr, exp_pa, "R1 physical address");
    check(tag, rd_cnt == exp_rd, 32'(rd_cnt), 32'(exp_rd), "read count");
    check("R2", rd_a0 == a1, rd_a0, a1, "directory read address");
    if (exp_rd == 2) check("R3", rd_a1 == a2, rd_a1, a2, "leaf read address");
    check(tag, wr_cnt == exp_wr, 32'(wr_cnt), 32'(exp_wr), "write-back count");
    if (exp_wr == 1) begin
      check("R7", wr_a == a2, wr_a, a2, "write-back address");
      check("R7", wr_d == exp_wd, wr_d, exp_wd, "write-back entry");
    end
    @(negedge clk);
    check("R9", !xl_done && xl_ready, {30'h0, xl_done, xl_ready}, 32'h1, "strobe drop and ready");
  endtask

  function automatic logic [31:0] va_of(input int i1, input int i2, input int off);
    return {i1[9:0], i2[8:0], off[12:0]};
  endfunction

  // directory entry for index i1 pointing at a leaf table
  task automatic set_dir(input int i1, input logic [31:0] ent);
    mem[ROOT + 32'(i1 * 4)] = ent;
  endtask
  task automatic set_leaf(input logic [31:0] dir_ent, input int i2, input logic [31:0] ent);
    mem[{dir_ent[31:13], 13'h0} + 32'(i2 * 4)] = ent;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; pt_root = ROOT;
    xl_valid = 1'b0; xl_vaddr = '0; xl_write = 1'b0; xl_user = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", xl_ready && !mem_req && !xl_done, {29'h0, xl_ready, mem_req, xl_done}, 32'h4, "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", xl_ready && !mem_req && !xl_done, {29'h0, xl_ready, mem_req, xl_done}, 32'h4, "after reset");

    // R4: directory entry invalid, junk in other bits
    set_dir(5, 32'h4000_201E);
    run_case("R4", va_of(5, 7, 16'h0123), 1'b0, 1'b0);

    // R5: leaf invalid
    d = 32'h4000_4001;
    set_dir(6, d);
    set_leaf(d, 3, 32'h0ABC_E01E);
    run_case("R5", va_of(6, 3, 16'h0456), 1'b1, 1'b0);

    // R6: write to read-only page, user allowed
    set_leaf(d, 4, 32'h0123_6019);
    run_case("R6", va_of(6, 4, 16'h0010), 1'b1, 1'b1);
    check("R6", rd(32'h4000_4010) == 32'h0123_6019, rd(32'h4000_4010), 32'h0123_6019, "entry untouched");
    // R6: user access to supervisor page, then supervisor read of same page
    set_leaf(d, 8, 32'h0055_A001);
    run_case("R6", va_of(6, 8, 16'h0777), 1'b0, 1'b1);
    run_case("R7", va_of(6, 8, 16'h0777), 1'b0, 1'b0);
    // R7: first write adds modified flag; R8: repeat write is silent
    run_case("R7", va_of(6, 8, 16'h0778), 1'b1, 1'b0);
    run_case("R8", va_of(6, 8, 16'h0779), 1'b1, 1'b0);
    run_case("R8", va_of(6, 8, 16'h0000), 1'b0, 1'b1 ^ 1'b1);

    // R6: protection bits on the directory entry have no effect
    d = 32'h4000_8019;
    set_dir(9, d);
    set_leaf(d, 1, 32'h00AA_C009);
    run_case("R6", va_of(9, 1, 16'h1FFF), 1'b1, 1'b1);

    // R1/R2/R3: extreme indices and offsets
    d = 32'h5FFF_E001;
    set_dir(1023, d);
    set_leaf(d, 511, 32'hFFFF_E00F);
    run_case("R1", 32'hFFFF_FFFF, 1'b1, 1'b1);
    set_dir(0, d);
    set_leaf(d, 0, 32'h0000_2009);
    run_case("R1", 32'h0000_0000, 1'b0, 1'b1);

    // random walks
    for (int n = 0; n < 200; n++) begin
      logic [31:0] va, e1, e2;
      va = $urandom;
      e1 = $urandom;
      e1[31:29] = 3'b010;
      e1[0] = ($urandom % 8) != 0;
      mem[ROOT + {20'h0, va[31:22], 2'b00}] = e1;
      e2 = $urandom;
      e2[0] = ($urandom % 6) != 0;
      if (e1[0]) mem[{e1[31:13], 13'h0} + {21'h0, va[21:13], 2'b00}] = e2;
      run_case("R7", va, 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule